// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 32-bit virtual address from the processor into a 28-bit physical address by looking it up in a single-level page table kept in main memory. Pages and frames are both 4 KiB. The upper 20 bits of the virtual address select a table entry. The lower 12 bits pass straight through as the byte offset. A table base register holds the table's location and is rewritten by system software on every process switch.

Each translation takes the following steps. The processor presents an address, and the block accepts it when idle. One cycle later the block issues exactly one memory read for the entry. It waits as many cycles as memory needs to return the entry. It then either delivers the physical frame joined to the offset or flags a page fault when the entry is not marked valid. Only one translation is in flight at a time. Caching of entries, multi-level tables and fault handling belong to other blocks.

Top module: `pt_xlate`

## Requirements
- R1: Out of reset, and whenever the block is idle, `reqReady` is 1 while `rspValid`, `rspFault` and `memRdReq` are 0; `reqReady` is 0 from the cycle after an acceptance until the response cycle has ended.
- R2: The cycle after a request is accepted (`reqValid` and `reqReady` both 1 at a clock edge), `memRdReq` is 1 for exactly one cycle. During that cycle `memRdAddr` equals the base register plus four times bits 31:12 of the accepted address, modulo 2^32. At all other times `memRdAddr` is 0.
- R3: An entry is returned while `memRdValid` is 1 and its bit 31 is 1. On the next cycle `rspValid` is 1, `rspFault` is 0 and `rspPaddr` equals entry bits 15:0 followed by the 12 offset bits.
- R4: An entry with bit 31 equal to 0 produces a response cycle with `rspFault` 1 and `rspPaddr` 0. Entry bits 30:16 never affect the result.
- R5: Bits 11:0 of the physical address equal bits 11:0 of the accepted virtual address, including the all-ones offset.
- R6: A base register write (`baseWe` 1) at an edge where the block is not idle is dropped. Later translations use the earlier base.
- R7: A base write at the same edge as a request acceptance takes effect for that request's entry address.
- R8: `reqValid` held high while a translation is in progress starts no second read and no second response.
- R9: `memRdValid` pulses that arrive while the block is not waiting for an entry are ignored. The block stays idle and the next translation is unaffected.
- R10: `rspValid` lasts exactly one cycle, and `reqReady` is 1 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baseWe | input | 1 | Write strobe for the table base register |
| baseData | input | 32 | New table base address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Response is a page fault |
| rspPaddr | output | 28 | Translated physical address, 0 unless a successful response |
| memRdReq | output | 1 | One-cycle memory read strobe for a table entry |
| memRdAddr | output | 32 | Byte address of the table entry |
| memRdValid | input | 1 | Memory returns the entry |
| memRdData | input | 32 | Table entry: bit 31 valid, bits 15:0 frame number |

## Verification
A base register write and a request acceptance can land on the same clock edge. A base write can also coincide with a translation that is already fetching or waiting. The bench creates both cases by driving `baseWe` together with `reqValid` in one case, and one cycle after acceptance in the other. It places distinct entries at the old and new table locations, so the returned frame shows which base was used for the read. A per-cycle model also compares the issued entry address. A stray `memRdValid` pulse during idle and a request held high through a busy translation complete the overlap cases.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } xlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptReq;  // capture virtual address
    logic loadBase;   // capture new table base
    logic issueRd;    // entry read in flight this cycle
    logic latchPte;   // capture returned frame number
    logic respond;    // response cycle
    logic fault;      // response is a fault
  } xlCtrl_t;

endpackage

// File: rtl/pt_xlate_ctrl.sv
module pt_xlate_ctrl
  import pt_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    baseWe,
  input  logic    memRdValid,
  input  logic    pteValid,
  output xlCtrl_t ctrl,
  output logic    reqReady,
  output logic    memRdReq,
  output logic    rspValid,
  output logic    rspFault
);

  xlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = ST_FETCH;
      ST_FETCH: stateD = ST_WAIT;
      ST_WAIT:  if (memRdValid) stateD = pteValid ? ST_DONE : ST_FAULT;
      ST_DONE:  stateD = ST_IDLE;
      ST_FAULT: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  logic isIdle;
  assign isIdle = (stateQ == ST_IDLE);

  always_comb begin
    ctrl.acceptReq = isIdle && reqValid;
    ctrl.loadBase  = isIdle && baseWe;
    ctrl.issueRd   = (stateQ == ST_FETCH);
    ctrl.latchPte  = (stateQ == ST_WAIT) && memRdValid;
    ctrl.respond   = (stateQ == ST_DONE) || (stateQ == ST_FAULT);
    ctrl.fault     = (stateQ == ST_FAULT);
  end

  assign reqReady = isIdle;
  assign memRdReq = ctrl.issueRd;
  assign rspValid = ctrl.respond;
  assign rspFault = ctrl.fault;

endmodule

// File: rtl/pt_xlate_dp.sv
module pt_xlate_dp
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 28,
  parameter int OFF_W     = 12,
  parameter int PTE_LOG2  = 2,
  parameter int VALID_BIT = 31,
  localparam int PTE_W    = 8 << PTE_LOG2,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PFN_W    = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xlCtrl_t          ctrl,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [VA_W-1:0]  baseData,
  input  logic [PTE_W-1:0] memRdData,
  output logic [VA_W-1:0]  memRdAddr,
  output logic             pteValid,
  output logic [PA_W-1:0]  rspPaddr
);

  logic [VA_W-1:0]  baseQ;
  logic [VA_W-1:0]  vaddrQ;
  logic [PFN_W-1:0] pfnQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             baseQ <= '0;
    else if (ctrl.loadBase) baseQ <= baseData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              vaddrQ <= '0;
    else if (ctrl.acceptReq) vaddrQ <= reqVaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pfnQ <= '0;
    else if (ctrl.latchPte) pfnQ <= memRdData[PFN_W-1:0];
  end

  // entry byte address: base plus scaled page number
  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  vpnScaled;
  assign vpn       = vaddrQ[VA_W-1:OFF_W];
  assign vpnScaled = {{OFF_W{1'b0}}, vpn} << PTE_LOG2;
  assign memRdAddr = ctrl.issueRd ? (baseQ + vpnScaled) : '0;

  assign pteValid = memRdData[VALID_BIT];

  logic unusedPteBits;
  assign unusedPteBits = ^memRdData[VALID_BIT-1:PFN_W];

  assign rspPaddr = (ctrl.respond && !ctrl.fault) ? {pfnQ, vaddrQ[OFF_W-1:0]} : '0;

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 28,
  parameter int OFF_W     = 12,
  parameter int PTE_LOG2  = 2,
  parameter int VALID_BIT = 31,
  localparam int PTE_W    = 8 << PTE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baseWe,
  input  logic [VA_W-1:0]  baseData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  output logic             rspValid,
  output logic             rspFault,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             memRdReq,
  output logic [VA_W-1:0]  memRdAddr,
  input  logic             memRdValid,
  input  logic [PTE_W-1:0] memRdData
);

  xlCtrl_t ctrl;
  logic    pteValid;

  pt_xlate_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .baseWe    (baseWe),
    .memRdValid(memRdValid),
    .pteValid  (pteValid),
    .ctrl      (ctrl),
    .reqReady  (reqReady),
    .memRdReq  (memRdReq),
    .rspValid  (rspValid),
    .rspFault  (rspFault)
  );

  pt_xlate_dp #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .OFF_W    (OFF_W),
    .PTE_LOG2 (PTE_LOG2),
    .VALID_BIT(VALID_BIT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .reqVaddr (reqVaddr),
    .baseData (baseData),
    .memRdData(memRdData),
    .memRdAddr(memRdAddr),
    .pteValid (pteValid),
    .rspPaddr (rspPaddr)
  );

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int PA_W = 28
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic            rspFault,
  input logic [PA_W-1:0] rspPaddr,
  input logic            memRdReq,
  input logic            memRdValid
);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (!rspValid && !memRdReq && !rspFault));

  // R2
  accept_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> memRdReq);

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdReq |=> !memRdReq);

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspFault |-> (rspValid && rspPaddr == '0));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reqReady && !rspValid) |=> !reqReady);

  // R9
  stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && memRdValid && !reqValid) |=> reqReady);

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> (!rspValid && reqReady));

endmodule

bind pt_xlate pt_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .rspFault  (rspFault),
  .rspPaddr  (rspPaddr),
  .memRdReq  (memRdReq),
  .memRdValid(memRdValid)
);

// File: tb/pt_xlate_tb.sv
module pt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baseWe = 1'b0;
  logic [31:0] baseData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        rspValid;
  logic        rspFault;
  logic [27:0] rspPaddr;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int readCount = 0;
  int memLat = 1;
  int latCnt = 0;
  bit strayReq = 1'b0;
  bit modelOn = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [31:0] memArr [logic [31:0]];

  always #10 clk = ~clk;

  pt_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .baseWe(baseWe), .baseData(baseData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .rspValid(rspValid), .rspFault(rspFault), .rspPaddr(rspPaddr),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 read, 2 wait, 3 respond
  int          mPhase = 0;
  logic [31:0] mBase = '0;
  logic [31:0] mVa = '0;
  logic [31:0] mPte = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPhase <= 0; mBase <= '0; mVa <= '0; mPte <= '0;
    end else begin
      case (mPhase)
        0: begin
          if (baseWe) mBase <= baseData;
          if (reqValid) begin mVa <= reqVaddr; mPhase <= 1; end
        end
        1: mPhase <= 2;
        2: if (memRdValid) begin mPte <= memRdData; mPhase <= 3; end
        default: mPhase <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic [31:0] expAddr;
    logic [27:0] expPa;
    logic        expFault;
    if (rst_n && modelOn) begin
      expAddr  = (mPhase == 1) ? mBase + {10'd0, mVa[31:12]} * 32'd4 : 32'd0;
      expFault = (mPhase == 3) && !mPte[31];
      expPa    = (mPhase == 3 && mPte[31]) ? {mPte[15:0], mVa[11:0]} : 28'd0;
      check(reqReady == (mPhase == 0), "R1 reqReady", {31'd0, reqReady}, {31'd0, mPhase == 0});
      check(memRdReq == (mPhase == 1), "R2 memRdReq", {31'd0, memRdReq}, {31'd0, mPhase == 1});
      check(memRdAddr == expAddr, "R2 memRdAddr", memRdAddr, expAddr);
      check(rspValid == (mPhase == 3), "R10 rspValid", {31'd0, rspValid}, {31'd0, mPhase == 3});
      check(rspFault == expFault, "R4 rspFault", {31'd0, rspFault}, {31'd0, expFault});
      check(rspPaddr == expPa, "R3 rspPaddr", {4'd0, rspPaddr}, {4'd0, expPa});
    end
  end

  // memory responder
  always @(negedge clk) begin
    memRdValid = 1'b0;
    memRdData  = '0;
    if (strayReq) begin
      memRdValid = 1'b1;
      memRdData  = 32'h8000_1234;
      strayReq   = 1'b0;
    end
    if (latCnt > 0) begin
      latCnt--;
      if (latCnt == 0) begin
        memRdValid = 1'b1;
        memRdData  = memArr.exists(pendAddr) ? memArr[pendAddr] : 32'd0;
      end
    end
    if (memRdReq) begin
      pendAddr = memRdAddr;
      latCnt   = memLat;
      readCount++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic writeBase(input logic [31:0] b);
    while (!reqReady) @(negedge clk);
    baseWe = 1'b1; baseData = b;
    @(negedge clk);
    baseWe = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit baseWithReq, input bit baseBusy,
                       input bit holdReq, input logic [31:0] nb,
                       output logic [27:0] pa, output bit f);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    if (baseWithReq) begin baseWe = 1'b1; baseData = nb; end
    @(negedge clk);
    baseWe = 1'b0;
    if (!holdReq) reqValid = 1'b0;
    if (baseBusy) begin baseWe = 1'b1; baseData = nb; end
    @(negedge clk);
    baseWe = 1'b0;
    if (holdReq) @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    pa = rspPaddr; f = rspFault;
    @(negedge clk);
  endtask

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0020_0000;

  initial begin
    logic [27:0] pa;
    bit          f;
    int          rdBefore;
    memArr[BASE_A + 32'h3E1 * 4]   = 32'h8000_0044;
    memArr[BASE_A + 32'h0]         = 32'h8000_0023;
    memArr[BASE_A + 32'hFFFFF * 4] = 32'hFFFF_FFFF;
    memArr[BASE_A + 32'h3E2 * 4]   = 32'h7FFF_0068;
    memArr[BASE_B + 32'h3E1 * 4]   = 32'h8000_0ABC;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady === 1'b1, "R1 reset reqReady", {31'd0, reqReady}, 32'd1);
    check(rspValid === 1'b0 && rspFault === 1'b0, "R1 reset rsp", {30'd0, rspValid, rspFault}, 32'd0);
    check(memRdReq === 1'b0, "R1 reset memRdReq", {31'd0, memRdReq}, 32'd0);
    rst_n = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);

    writeBase(BASE_A);

    // R3 example translation
    xlate(32'h003E_1234, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'h004_4234, "R3 mapped page", {4'd0, pa}, 32'h0044234);

    // R5 all-ones offset, slower memory
    memLat = 2;
    xlate(32'h0000_0FFF, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'h002_3FFF, "R5 offset passthrough", {4'd0, pa}, 32'h0023FFF);

    // R2 top page number, R4 upper entry bits ignored
    xlate(32'hFFFF_F000, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'hFFF_F000, "R2 top page", {4'd0, pa}, 32'hFFFF000);

    // R4 invalid entry with other bits set
    xlate(32'h003E_2ABC, 0, 0, 0, 0, pa, f);
    check(f && pa == 28'd0, "R4 invalid entry", {3'd0, f, pa}, 32'h1000_0000);

    // R4 unmapped entry reads as zero
    memLat = 1;
    xlate(32'h00A0_0000, 0, 0, 0, 0, pa, f);
    check(f && pa == 28'd0, "R4 empty entry", {3'd0, f, pa}, 32'h1000_0000);

    // R6 base write while busy is dropped
    xlate(32'h003E_1001, 0, 1, 0, BASE_B, pa, f);
    check(!f && pa == 28'h004_4001, "R6 busy write same xlate", {4'd0, pa}, 32'h0044001);
    xlate(32'h003E_1002, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'h004_4002, "R6 old base kept", {4'd0, pa}, 32'h0044002);

    // R7 base write together with acceptance
    xlate(32'h003E_1003, 1, 0, 0, BASE_B, pa, f);
    check(!f && pa == 28'hABC_003, "R7 same-edge base", {4'd0, pa}, 32'h0ABC003);

    // R8 request held high while busy
    memLat = 4;
    rdBefore = readCount;
    xlate(32'h003E_1004, 0, 0, 1, 0, pa, f);
    check(!f && pa == 28'hABC_004, "R8 held request result", {4'd0, pa}, 32'h0ABC004);
    repeat (3) @(negedge clk);
    check(readCount - rdBefore == 1, "R8 single read", readCount - rdBefore, 32'd1);
    check(reqReady && !rspValid, "R8 idle after hold", {30'd0, reqReady, rspValid}, 32'd2);

    // R9 stray entry return while idle
    memLat = 1;
    @(posedge clk);
    strayReq = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !memRdReq, "R9 stray ignored",
          {29'd0, reqReady, rspValid, memRdReq}, 32'd4);
    xlate(32'h003E_1FFF, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'hABC_FFF, "R9 next xlate intact", {4'd0, pa}, 32'h0ABCFFF);

    // R10 back-to-back requests
    writeBase(BASE_A);
    xlate(32'h003E_1010, 0, 0, 0, 0, pa, f);
    xlate(32'h0000_0020, 0, 0, 0, 0, pa, f);
    check(!f && pa == 28'h002_3020, "R10 back to back", {4'd0, pa}, 32'h0023020);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule